// File: doc/BRIEF.md
# Four-Phase Interlocked Bus Transfer Controller

This block carries single read and write transfers between a requester-side engine and a small register store over two control lines: a strobe owned by the requester and an acknowledge owned by the responder. Both sides share one clock. Each side sees the other's control line only through a two-flop synchronizer, so the protocol must hold up with no fixed timing between the two sides.

Every control edge waits for the opposite side's previous edge, which gives the sequence: strobe up, acknowledge up, strobe down, acknowledge down. The responder delays its acknowledge by a programmable number of cycles, with one count for writes and one for reads, so that its own hold needs are met. On reads, the requester delays dropping the strobe by a programmable count before it samples the returned data. A transfer therefore lasts as long as the responder takes. Completion is known only when the second round trip of the control lines has finished.

A user presents a command with `req_valid`. The user then waits for the one-cycle `done` pulse, and on reads takes `rd_data`.

Top module: `hsk_bus_top`

## Requirements
- R1: After reset, `bus_strobe`, `bus_ack`, `busy` and `done` are 0 and `rd_data` is 0.
- R2: The strobe rises only while the synchronized acknowledge is low. The acknowledge rises only after the synchronized strobe is seen high. The strobe falls only after the synchronized acknowledge is seen high. The acknowledge falls only after the synchronized strobe is seen low. When `done` pulses, both lines are low.
- R3: A write accepted on rising edge 0 raises `done` after rising edge 12 + WR_ACK_DLY.
- R4: A read accepted on rising edge 0 raises `done` after rising edge 12 + RD_ACK_DLY + STB_REL_DLY.
- R5: A write stores `req_wdata` at `req_addr`. A later read of that address returns it on `rd_data`, and `rd_data` holds that value from `done` until the next read completes.
- R6: From strobe assertion until the transfer completes, the address, direction and write data on the bus stay at the values taken when the request was accepted.
- R7: `done` is high for exactly one cycle. `busy` is 1 from the edge after acceptance until `done`, and it is 0 while `done` is high.
- R8: `req_valid` is ignored while `busy` is 1. Such a request produces no transfer, no extra `done` pulse and no change to the store.
- R9: After reset, every address of the store reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a transfer (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Target address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Data returned by the last read |
| bus_strobe | output | 1 | Requester control line, brought out for observation |
| bus_ack | output | 1 | Responder control line, brought out for observation |

## Verification
The bench starts with a read sweep over every address right after reset, which shows the cleared store and the read latency, including the strobe-release hold. It then writes a distinct arithmetic pattern to every address and reads it back, so the write latency and the acknowledge delay chosen by direction are told apart from the read path. A request injected during a write shows whether the controller latches a second command or disturbs the bus fields it holds. Each transfer is timed edge by edge against the latency formulas, so a missing synchronizer stage or a miscounted delay shows up.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  typedef enum logic [1:0] {
    M_IDLE     = 2'd0,
    M_WAIT_ACK = 2'd1,
    M_HOLD     = 2'd2,
    M_WAIT_REL = 2'd3
  } mst_state_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_DELAY = 2'd1,
    S_ACKED = 2'd2
  } slv_state_t;

  // counter width able to reach the given delay, never below one bit
  function automatic int cnt_width(input int max_dly);
    return $clog2(max_dly + 2);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/hsk_master.sv
module hsk_master #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int STB_REL_DLY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_stb,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              ack_s
);
  import hsk_pkg::*;

  localparam int CW = cnt_width(STB_REL_DLY);
  localparam logic [CW-1:0] REL_C = CW'(STB_REL_DLY);

  mst_state_t    state;
  logic [CW-1:0] cnt;

  // named internal events
  logic take_req, ack_seen, rel_now, ack_gone;
  assign take_req = (state == M_IDLE) && req_valid && !ack_s;
  assign ack_seen = (state == M_WAIT_ACK) && ack_s;
  assign rel_now  = (ack_seen && (bus_wr || STB_REL_DLY == 0)) ||
                    ((state == M_HOLD) && (cnt == REL_C));
  assign ack_gone = (state == M_WAIT_REL) && !ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= M_IDLE;
      cnt       <= '0;
      bus_stb   <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rd_data   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take_req) begin
        bus_addr  <= req_addr;
        bus_wr    <= req_write;
        bus_wdata <= req_wdata;
        bus_stb   <= 1'b1;
        state     <= M_WAIT_ACK;
      end
      if (ack_seen && !rel_now) begin
        cnt   <= CW'(1);
        state <= M_HOLD;
      end else if (state == M_HOLD && !rel_now) begin
        cnt <= cnt + CW'(1);
      end
      if (rel_now) begin
        if (!bus_wr) rd_data <= bus_rdata;
        bus_stb <= 1'b0;
        state   <= M_WAIT_REL;
      end
      if (ack_gone) begin
        done  <= 1'b1;
        state <= M_IDLE;
      end
    end
  end

  assign busy = (state != M_IDLE);

  a_r2_stb_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_stb) |-> $past(!ack_s));
  a_r2_stb_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_stb) |-> $past(ack_s));
  a_r6_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata)));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/hsk_slave.sv
module hsk_slave #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int WR_ACK_DLY = 2,
  parameter int RD_ACK_DLY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_s,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ack
);
  import hsk_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = cnt_width(max2(WR_ACK_DLY, RD_ACK_DLY));
  localparam logic [CW-1:0] WR_C = CW'(WR_ACK_DLY);
  localparam logic [CW-1:0] RD_C = CW'(RD_ACK_DLY);

  slv_state_t        state;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     dly_sel;
  logic [DATA_W-1:0] store [DEPTH];

  logic          stb_seen, ack_now, stb_gone;
  logic [CW-1:0] dly_pick;
  assign stb_seen = (state == S_IDLE) && stb_s;
  assign dly_pick = bus_wr ? WR_C : RD_C;
  assign ack_now  = (stb_seen && dly_pick == '0) ||
                    ((state == S_DELAY) && (cnt == dly_sel));
  assign stb_gone = (state == S_ACKED) && !stb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      dly_sel   <= '0;
      bus_rdata <= '0;
      ack       <= 1'b0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      if (stb_seen) begin
        dly_sel   <= dly_pick;
        bus_rdata <= store[bus_addr];
        if (bus_wr) store[bus_addr] <= bus_wdata;
        if (!ack_now) begin
          cnt   <= CW'(1);
          state <= S_DELAY;
        end
      end else if (state == S_DELAY && !ack_now) begin
        cnt <= cnt + CW'(1);
      end
      if (ack_now) begin
        ack   <= 1'b1;
        state <= S_ACKED;
      end
      if (stb_gone) begin
        ack   <= 1'b0;
        state <= S_IDLE;
      end
    end
  end

  a_r2_ack_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(stb_s));
  a_r2_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> $past(!stb_s));
  a_r2_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && stb_s) |=> ack);
endmodule

// File: rtl/hsk_bus_top.sv
module hsk_bus_top #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int WR_ACK_DLY  = 2,
  parameter int RD_ACK_DLY  = 3,
  parameter int STB_REL_DLY = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_strobe,
  output logic              bus_ack
);
  logic              stb_s, ack_s, bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;

  hsk_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STB_REL_DLY(STB_REL_DLY)) u_mst (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .bus_stb(bus_strobe), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_s(ack_s)
  );

  hsk_sync #(.STAGES(SYNC_STAGES)) u_sync_stb (
    .clk(clk), .rst_n(rst_n), .d_in(bus_strobe), .q_out(stb_s)
  );

  hsk_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
    .clk(clk), .rst_n(rst_n), .d_in(bus_ack), .q_out(ack_s)
  );

  hsk_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
              .WR_ACK_DLY(WR_ACK_DLY), .RD_ACK_DLY(RD_ACK_DLY)) u_slv (
    .clk(clk), .rst_n(rst_n), .stb_s(stb_s), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack(bus_ack)
  );
endmodule

// File: tb/hsk_bus_top_tb.sv
module hsk_bus_top_tb;
  localparam int AW = 4, DW = 8, WRD = 2, RDD = 3, REL = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic busy, done, bus_strobe, bus_ack;
  logic [DW-1:0] rd_data;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  hsk_bus_top #(.ADDR_W(AW), .DATA_W(DW), .WR_ACK_DLY(WRD), .RD_ACK_DLY(RDD),
                .STB_REL_DLY(REL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .bus_strobe(bus_strobe), .bus_ack(bus_ack)
  );

  function automatic int lat(input bit wr);
    return wr ? (12 + WRD) : (12 + RDD + REL);
  endfunction

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 5) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one transfer; optional stray request injected mid-flight
  task automatic xfer(input bit wr, input int a, input int d, input bit inject,
                      output logic [DW-1:0] rdv);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = DW'(d);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    n = 0;
    while (!done && n < 200) begin
      if (inject && n == 3) begin
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = AW'(a + 1); req_wdata = 8'hAA;
      end else begin
        req_valid = 1'b0;
        req_addr = AW'(a); req_wdata = DW'(d);
      end
      @(posedge clk); n++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(n == lat(wr), wr ? "R3 write latency" : "R4 read latency", n, lat(wr));
    chk(!busy, "R7 busy low at done", int'(busy), 0);
    chk(!bus_strobe && !bus_ack, "R2 lines low at done",
        int'({bus_strobe, bus_ack}), 0);
    @(posedge clk); @(negedge clk);
    chk(!done, "R7 done one cycle", int'(done), 0);
    rdv = rd_data;
  endtask

  initial begin
    logic [DW-1:0] v;
    #35;
    chk(!bus_strobe && !bus_ack && !busy && !done && rd_data == '0,
        "R1 reset outputs", int'({bus_strobe, bus_ack, busy, done}), 0);
    rst_n = 1'b1;
    for (int a = 0; a < (1 << AW); a++) begin
      xfer(1'b0, a, 0, 1'b0, v);
      chk(v == '0, "R9 cleared store", int'(v), 0);
    end
    for (int a = 0; a < (1 << AW); a++) xfer(1'b1, a, int'(pat(a)), 1'b0, v);
    for (int a = (1 << AW) - 1; a >= 0; a--) begin
      xfer(1'b0, a, 0, 1'b0, v);
      chk(v == pat(a), "R5 readback", int'(v), int'(pat(a)));
    end
    // R8: stray request during a write to 3 targets 4; R6: 3 keeps its own data
    xfer(1'b1, 3, 8'h5C, 1'b1, v);
    repeat (30) begin
      @(negedge clk);
      chk(!done && !busy, "R8 no extra transfer", int'({busy, done}), 0);
    end
    xfer(1'b0, 4, 0, 1'b0, v);
    chk(v == pat(4), "R8 store untouched", int'(v), int'(pat(4)));
    xfer(1'b0, 3, 0, 1'b0, v);
    chk(v == 8'h5C, "R6 held write data", int'(v), 32'h5C);
    repeat (5) @(negedge clk);
    chk(rd_data == 8'h5C, "R5 rd_data holds", int'(rd_data), 32'h5C);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule